// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output from a small word-wide register port. Software sets a period and then streams duty values into a four-entry queue. The counter consumes one queued value per full output period. The output is high while the running count is below the duty value in use. When the queue runs dry, the last duty value stays in force, so the waveform never stops mid-stream.

The counter advances on a tick. The tick is one of several synchronous source strobes, picked by a select field and then divided by a programmable prescaler. One full period lasts the programmed period value plus two ticks. A status word gives the queue fill level and a sticky flag for writes that were lost to a full queue. A self-clearing reset bit in the control word returns the whole block to its reset state. Three more control bits are stored and read back for system power-state policy, and have no effect inside the block.

Top module: `duty_fifo_pwm`

## Requirements
- R1: After reset, every register reads zero, the fill level is 0 and `pwm_out` is low.
- R2: A period spans PERIOD+2 ticks, and within it `pwm_out` is high for min(S, PERIOD+2) ticks, where S is the duty value in use (S=0 gives a constantly low output).
- R3: The 12-bit prescaler field at control bits [15:4] makes the counter advance once every field+1 strobes of the selected source.
- R4: Control bits [2:1] select which bit of `src_tick` clocks the counter. A source that never strobes freezes the count.
- R5: Duty values written to address 2 are queued up to four deep and used in write order. One is taken when the block is enabled and one at each period end. The fill level reads at status bits [2:0].
- R6: At a period end with an empty queue, the duty value in use is kept. Address 2 reads back the duty value in use.
- R7: A duty write while the queue holds four entries and nothing leaves is dropped, and it sets status bit 7. That bit stays set until a write with bit 7 = 1 to address 1.
- R8: A duty write in the same cycle that a period end takes an entry from a full queue is accepted, and it sets no overflow flag.
- R9: With the enable bit (control bit 0) low, the count holds at zero, the output is low and no queued entry is used. The cycle after the enable goes high, the head entry becomes the duty value in use.
- R10: Writing 1 to control bit 3 makes that bit read 1 for one cycle. The block then clears the queue, the overflow flag and all registers, and the bit reads 0.
- R11: Control bits [18:16] are stored and read back unchanged, and they do not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 duty, 3 period |
| wr_data | input | DW (24) | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | DW (24) | Combinational read data |
| src_tick | input | NSRC (4) | Synchronous strobes of the candidate count sources |
| pwm_out | output | 1 | Modulated output |

## Verification
Two things can land on the same clock edge: a duty write, and the period end that takes an entry from the queue. The case that matters is a write into a full queue on the very edge that frees a slot. The bench provokes it by counting edges from the enable write, which lets it place writes exactly on a known period end and on the edge after it. On the first of these edges the fill level must stay at four with the overflow flag clear. On the second the write must be dropped and the flag must rise. The order in which later duty values take effect, read back period by period, shows that the accepted value went in behind the others.

// File: rtl/duty_fifo_pwm_pkg.sv
package duty_fifo_pwm_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_STAT   = 2'd1,
      REG_DUTY   = 2'd2,
      REG_PERIOD = 2'd3
   } reg_sel_e;

   localparam int CTL_RUN_BIT  = 0;
   localparam int CTL_SRC_LSB  = 1;
   localparam int CTL_RST_BIT  = 3;
   localparam int CTL_PRE_LSB  = 4;
   localparam int CTL_HOLD_LSB = 16;
   localparam int CTL_HOLD_W   = 3;
   localparam int STAT_OVF_BIT = 7;

endpackage

// File: rtl/dfp_tick_gen.sv
module dfp_tick_gen #(
   parameter int NSRC  = 4,
   parameter int PRE_W = 12,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SEL_W-1:0] sel,
   input  logic [PRE_W-1:0] presc,
   output logic             tick
);

   logic             src;
   logic [PRE_W-1:0] div_q;
   logic             div_end;

   generate
      if (NSRC == 1) begin : g_single
         assign src = src_tick[0];
      end else begin : g_mux
         assign src = src_tick[sel];
      end
   endgenerate

   assign div_end = (div_q >= presc);
   assign tick    = src & div_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr) begin
         div_q <= '0;
      end else if (src) begin
         div_q <= div_end ? '0 : div_q + PRE_W'(1);
      end
   end

endmodule

// File: rtl/dfp_sample_fifo.sv
module dfp_sample_fifo #(
   parameter int DEPTH = 4,
   parameter int DW    = 24,
   parameter int LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          push_ok,
   output logic [LW-1:0] level
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dfp_sample_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] cnt_q;
   logic          do_pop;

   assign empty   = (cnt_q == '0);
   assign do_pop  = pop & ~empty;
   assign push_ok = push & ((cnt_q != LW'(DEPTH)) | do_pop);
   assign head    = mem[rp_q];
   assign level   = cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok && !flush) begin
         mem[wp_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         if (push_ok && !do_pop)      cnt_q <= cnt_q + LW'(1);
         else if (do_pop && !push_ok) cnt_q <= cnt_q - LW'(1);
      end
   end

endmodule

// File: rtl/dfp_period_core.sv
module dfp_period_core #(
   parameter int PW      = 24,
   parameter int OUT_REG = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          tick,
   input  logic [PW-1:0] period,
   input  logic [PW-1:0] head,
   input  logic          empty,
   output logic          pop,
   output logic [PW-1:0] active,
   output logic          pwm
);

   localparam int CW = PW + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;
   logic [PW-1:0] active_q;
   logic          fresh_q;
   logic          at_end;
   logic          hi;

   assign last   = {1'b0, period} + CW'(1);
   assign at_end = (cnt_q >= last);
   assign pop    = run & (fresh_q | (tick & at_end));
   assign active = active_q;
   assign hi     = run & ~fresh_q & (cnt_q < {1'b0, active_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= '0;
         fresh_q  <= 1'b1;
      end else if (clr || !run) begin
         cnt_q   <= '0;
         fresh_q <= 1'b1;
         if (clr) active_q <= '0;
      end else if (fresh_q) begin
         fresh_q <= 1'b0;
         cnt_q   <= '0;
         if (!empty) active_q <= head;
      end else if (tick) begin
         if (at_end) begin
            cnt_q <= '0;
            if (!empty) active_q <= head;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   generate
      if (OUT_REG != 0) begin : g_out_reg
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pwm_q <= 1'b0;
            else if (clr) pwm_q <= 1'b0;
            else          pwm_q <= hi;
         end
         assign pwm = pwm_q;
      end else begin : g_out_comb
         assign pwm = hi;
      end
   endgenerate

endmodule

// File: rtl/duty_fifo_pwm.sv
module duty_fifo_pwm
   import duty_fifo_pwm_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int DW      = 24,
   parameter int PW      = 24,
   parameter int PRE_W   = 12,
   parameter int NSRC    = 4,
   parameter int OUT_REG = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [1:0]      rd_addr,
   output logic [DW-1:0]   rd_data,
   input  logic [NSRC-1:0] src_tick,
   output logic            pwm_out
);

   localparam int LW    = $clog2(DEPTH + 1);
   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (DW < PW || DW < CTL_HOLD_LSB + CTL_HOLD_W || PRE_W > 12 || PRE_W < 1 ||
          NSRC < 1 || NSRC > 4 || LW > STAT_OVF_BIT) begin : g_bad_cfg
         $error("duty_fifo_pwm: parameter set does not fit the register layout");
      end
   endgenerate

   logic                  en_q;
   logic [SEL_W-1:0]      src_q;
   logic [PRE_W-1:0]      pre_q;
   logic [CTL_HOLD_W-1:0] hold_q;
   logic                  swr_q;
   logic [PW-1:0]         period_q;
   logic                  ovf_q;

   logic                  wr_ctrl, wr_stat, wr_period;
   logic                  push_req, push_ok;
   logic                  tick, core_pop, fifo_empty;
   logic [PW-1:0]         fifo_head, active;
   logic [LW-1:0]         fifo_level;

   assign wr_ctrl   = wr_en & (reg_sel_e'(wr_addr) == REG_CTRL);
   assign wr_stat   = wr_en & (reg_sel_e'(wr_addr) == REG_STAT);
   assign wr_period = wr_en & (reg_sel_e'(wr_addr) == REG_PERIOD);
   assign push_req  = wr_en & (reg_sel_e'(wr_addr) == REG_DUTY) & ~swr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         src_q    <= '0;
         pre_q    <= '0;
         hold_q   <= '0;
         swr_q    <= 1'b0;
         period_q <= '0;
         ovf_q    <= 1'b0;
      end else if (swr_q) begin
         en_q     <= 1'b0;
         src_q    <= '0;
         pre_q    <= '0;
         hold_q   <= '0;
         swr_q    <= 1'b0;
         period_q <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= wr_data[CTL_RUN_BIT];
            src_q  <= wr_data[CTL_SRC_LSB +: SEL_W];
            pre_q  <= wr_data[CTL_PRE_LSB +: PRE_W];
            hold_q <= wr_data[CTL_HOLD_LSB +: CTL_HOLD_W];
            swr_q  <= wr_data[CTL_RST_BIT];
         end
         if (wr_period) period_q <= wr_data[PW-1:0];
         if (push_req && !push_ok)                ovf_q <= 1'b1;
         else if (wr_stat && wr_data[STAT_OVF_BIT]) ovf_q <= 1'b0;
      end
   end

   dfp_tick_gen #(
      .NSRC  (NSRC),
      .PRE_W (PRE_W),
      .SEL_W (SEL_W)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (swr_q | ~en_q),
      .src_tick (src_tick),
      .sel      (src_q),
      .presc    (pre_q),
      .tick     (tick)
   );

   dfp_sample_fifo #(
      .DEPTH (DEPTH),
      .DW    (PW),
      .LW    (LW)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (swr_q),
      .push    (push_req),
      .wdata   (wr_data[PW-1:0]),
      .pop     (core_pop),
      .head    (fifo_head),
      .empty   (fifo_empty),
      .push_ok (push_ok),
      .level   (fifo_level)
   );

   dfp_period_core #(
      .PW      (PW),
      .OUT_REG (OUT_REG)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (swr_q),
      .run    (en_q),
      .tick   (tick),
      .period (period_q),
      .head   (fifo_head),
      .empty  (fifo_empty),
      .pop    (core_pop),
      .active (active),
      .pwm    (pwm_out)
   );

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_addr))
         REG_CTRL: begin
            rd_data[CTL_RUN_BIT]                 = en_q;
            rd_data[CTL_SRC_LSB +: SEL_W]        = src_q;
            rd_data[CTL_RST_BIT]                 = swr_q;
            rd_data[CTL_PRE_LSB +: PRE_W]        = pre_q;
            rd_data[CTL_HOLD_LSB +: CTL_HOLD_W]  = hold_q;
         end
         REG_STAT: begin
            rd_data[LW-1:0]       = fifo_level;
            rd_data[STAT_OVF_BIT] = ovf_q;
         end
         REG_DUTY:   rd_data[PW-1:0] = active;
         REG_PERIOD: rd_data[PW-1:0] = period_q;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/duty_fifo_pwm_chk.sv
module duty_fifo_pwm_chk #(
   parameter int DEPTH = 4,
   parameter int LW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          swr,
   input logic          ovf,
   input logic          push_req,
   input logic          push_ok,
   input logic          pop,
   input logic [LW-1:0] level,
   input logic          pwm
);

   // R5
   fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   // R9
   idle_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm);

   // R9
   idle_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !swr) |=> (level >= $past(level)));

   // R10
   soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swr |=> (!swr && level == '0 && !ovf && !run));

   // R7
   drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !push_ok && !swr) |=> ovf);

   // R8
   full_pop_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop && level == LW'(DEPTH)) |-> push_ok);

endmodule

bind duty_fifo_pwm duty_fifo_pwm_chk #(
   .DEPTH (DEPTH),
   .LW    (LW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (en_q),
   .swr      (swr_q),
   .ovf      (ovf_q),
   .push_req (push_req),
   .push_ok  (push_ok),
   .pop      (core_pop),
   .level    (fifo_level),
   .pwm      (pwm_out)
);

// File: tb/sim_duty_fifo_pwm.sv
module sim_duty_fifo_pwm;

   localparam int CYC = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [23:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [23:0] rd_data;
   logic        tog = 1'b0;
   logic [3:0]  src_tick;
   logic        pwm_out;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #(CYC / 2) clk = ~clk;
   always @(negedge clk) tog <= ~tog;
   assign src_tick = {1'b1, 1'b1, tog, 1'b0};

   duty_fifo_pwm u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .src_tick (src_tick),
      .pwm_out  (pwm_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_addr = 2'(a);
      wr_data = 24'(d);
      wr_en   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = 2'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic count_hi(input int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         h += int'(pwm_out);
      end
   endtask

   function automatic int ctrlw(int en, int src, int pre, int hold);
      return en | (src << 1) | (pre << 4) | (hold << 16);
   endfunction

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic run_case(input string req, input int src, input int pre,
                           input int per, input int duty, input int mult, input int exp_hi);
      int h;
      wr(0, ctrlw(0, src, 0, 0));
      wr(3, per);
      wr(2, duty);
      wr(0, ctrlw(1, src, pre, 0));
      repeat (2 * (per + 2) * mult + 3) @(negedge clk);
      count_hi(3 * (per + 2) * mult, h);
      chk(req, h, exp_hi);
   endtask

   initial begin
      #(CYC * 100000);
      fails++;
      $display("FAIL watchdog expired");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      end
      $finish;
   end

   initial begin
      int v;
      int h;
      int sum;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(a, v);
         chk("R1 register reset", v, 0);
      end
      chk("R1 output reset", int'(pwm_out), 0);

      // R2: sweep of period and duty, fastest source, no prescale
      for (int p = 3; p <= 8; p++) begin
         for (int s = 0; s <= p + 3; s++) begin
            run_case("R2 high ticks per window", 2, 0, p, s, 1, 3 * imin(s, p + 2));
         end
      end

      // R3: prescaler divides by field + 1
      for (int pre = 1; pre <= 3; pre++) begin
         run_case("R3 prescaled high count", 2, pre, 4, 2, pre + 1, 3 * 2 * (pre + 1));
      end

      // R4: source select, half-rate source and a stopped source
      run_case("R4 half-rate source", 1, 0, 4, 2, 2, 12);
      run_case("R4 stopped source holds count", 0, 0, 4, 2, 1, 18);

      // queue sequence: soft reset to a clean state first
      wr(0, ctrlw(0, 0, 0, 0) | 8);
      @(negedge clk);
      wr(3, 6);
      wr(2, 1);
      wr(2, 7);
      wr(2, 8);
      wr(2, 3);
      rd(1, v);
      chk("R5 level after four writes", v & 7, 4);
      wr(2, 5);
      rd(1, v);
      chk("R7 drop sets overflow", (v >> 7) & 1, 1);
      chk("R7 level unchanged on drop", v & 7, 4);
      wr(1, 1 << 7);
      rd(1, v);
      chk("R7 overflow cleared by write one", (v >> 7) & 1, 0);

      wr(0, ctrlw(1, 2, 0, 0));
      sum = 0;
      for (int k = 1; k <= 32; k++) begin
         @(negedge clk);
         sum += int'(pwm_out);
         if (k == 5) begin
            rd(2, v); chk("R5 first duty in use", v, 1);
            rd(1, v); chk("R5 level after first use", v & 7, 3);
         end
         if (k == 13) begin
            rd(2, v); chk("R5 second duty in use", v, 7);
            rd(1, v); chk("R5 level after second use", v & 7, 2);
         end
         if (k == 21) begin
            rd(2, v); chk("R5 third duty in use", v, 8);
            rd(1, v); chk("R5 level after third use", v & 7, 1);
         end
         if (k == 29) begin
            rd(2, v); chk("R5 fourth duty in use", v, 3);
            rd(1, v); chk("R5 level after fourth use", v & 7, 0);
         end
      end
      chk("R2 four-period high total", sum, 19);

      wr(2, 2);
      rd(2, v);
      chk("R6 empty queue repeats duty", v, 3);
      wr(2, 4);
      wr(2, 6);
      wr(2, 5);
      rd(1, v);
      chk("R5 level refilled", v & 7, 4);
      repeat (4) @(negedge clk);
      wr(2, 9);
      rd(1, v);
      chk("R8 level stays full on pop and push", v & 7, 4);
      chk("R8 no overflow on pop and push", (v >> 7) & 1, 0);
      rd(2, v);
      chk("R8 boundary took head entry", v, 2);
      wr(2, 1);
      rd(1, v);
      chk("R7 full write dropped", (v >> 7) & 1, 1);
      chk("R7 level full after drop", v & 7, 4);
      repeat (7) @(negedge clk);
      rd(2, v);
      chk("R5 order continues", v, 4);

      // R9: disabled block holds
      wr(0, ctrlw(0, 2, 0, 0));
      count_hi(40, h);
      chk("R9 output low while disabled", h, 0);
      rd(1, v);
      chk("R9 no entries used while disabled", v & 7, 3);
      wr(0, ctrlw(1, 2, 0, 0));
      @(negedge clk);
      rd(2, v);
      chk("R9 head loaded after enable", v, 6);
      rd(1, v);
      chk("R9 level after enable load", v & 7, 2);

      // R11: stored-only control bits
      wr(0, ctrlw(0, 2, 5, 5));
      rd(0, v);
      chk("R11 control readback", v, ctrlw(0, 2, 5, 5));
      count_hi(10, h);
      chk("R11 output unaffected", h, 0);
      rd(1, v);
      chk("R7 overflow stays sticky", v, 2 | (1 << 7));

      // R10: self-clearing soft reset
      wr(0, 8);
      rd(0, v);
      chk("R10 reset bit reads one", v, 8);
      @(negedge clk);
      rd(0, v);
      chk("R10 control cleared", v, 0);
      rd(1, v);
      chk("R10 status cleared", v, 0);
      rd(3, v);
      chk("R10 period cleared", v, 0);
      rd(2, v);
      chk("R10 duty cleared", v, 0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      end
      $finish;
   end

endmodule